// File: doc/BRIEF.md
# Per-Link Descriptor Queue Manager

This block sits between a packet classifier and an output stage. Each cycle it can take in one packet descriptor and hand out one. A descriptor carries flags, a queue number, an output virtual interface, a 20-bit packet pointer and an 11-bit length. Accepted descriptors are linked onto the tail of one queue. Queues are grouped into sets: one set for each virtual link and one extra set for the plugin path. Descriptor storage is a small on-chip pool. A free list hands out pool slots and takes them back.

Within a set, the lowest queue numbers form a fixed datagram region and the rest are reserved queues. A flag in the descriptor says which region it targets. When the output stage asks for work, the block picks a set in round-robin order and then a non-empty queue in that set, also in round-robin order. It pops the head descriptor and returns it one cycle later. The returned descriptor carries the number of descriptors still waiting in that queue and a strobe that tells the output stage the payload buffer may be freed once sent.

Top module: `qm_vlink_queue_mgr`

## Requirements
- R1: After reset, out_valid and out_release are 0, refuse_cnt is 0 and every queue is empty, so a dequeue request returns nothing.
- R2: Descriptors placed in one queue leave it in arrival order, with pointer, flags, interface and length unchanged.
- R3: A descriptor with flag bit 0 (drop) set is never placed in a queue and does not change refuse_cnt.
- R4: Flag bit 1 (plugin) sends a descriptor to the plugin set, which has set index LINKS, whatever its interface value. Without that flag the set is in_vif, and an in_vif of LINKS or more is refused.
- R5: With flag bit 2 (datagram) set, the queue is in_qid modulo DGQ, inside the datagram region. Without it, in_qid must lie in [DGQ, NQ) or the descriptor is refused. out_qid reports the queue actually used.
- R6: If all POOL descriptor slots are taken, an enqueue is refused and refuse_cnt goes up by one. A dequeue in the same cycle does not make room for it.
- R7: When deq_req is high and any queue holds a descriptor, out_valid is high in the next cycle with the popped descriptor. Otherwise out_valid is low in the next cycle.
- R8: Sets are served round-robin in index order, starting after the set served last. After reset, set 0 comes first.
- R9: Within a set, non-empty queues are served round-robin in queue order, starting after the queue last served in that set. After reset, queue 0 comes first.
- R10: out_release is high together with out_valid exactly when the returned descriptor has flag bit 3 (final copy) set.
- R11: out_qlen gives the number of descriptors left in the served queue after the pop. An arrival to that same queue in the same cycle is counted.
- R12: An enqueue and a dequeue on the same queue in one cycle, while that queue holds a single descriptor, leave the new descriptor as the queue's only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered this cycle |
| in_flags | input | 16 | Descriptor flags (bit0 drop, bit1 plugin, bit2 datagram, bit3 final copy) |
| in_qid | input | 10 | Requested queue number |
| in_vif | input | 5 | Output virtual interface, which selects the link set |
| in_ptr | input | 20 | Packet buffer pointer |
| in_len | input | 11 | Packet length |
| deq_req | input | 1 | Output stage asks for one descriptor |
| out_valid | output | 1 | Returned descriptor valid |
| out_flags | output | 16 | Flags of the returned descriptor |
| out_qid | output | 10 | Queue the descriptor was held in |
| out_vif | output | 5 | Interface of the returned descriptor |
| out_ptr | output | 20 | Packet pointer of the returned descriptor |
| out_len | output | 11 | Length of the returned descriptor |
| out_qlen | output | 24 | Descriptors left in that queue |
| out_release | output | 1 | Payload buffer may be freed after sending |
| refuse_cnt | output | 16 | Count of refused enqueues |

## Verification
An enqueue and a dequeue can fall in the same cycle. Three overlaps matter most: both touch the same queue while it holds one entry; both touch the same queue while it holds several, where the reported length must count the arrival; and the pool is full while a slot is being freed, where the arrival must still be refused. Directed steps set up each of these cases, and a random phase alternates between fill-heavy and drain-heavy stretches so that they recur with varied queues. Every returned descriptor, its length report and the refusal count are compared with a bench model of per-queue lists and round-robin pointers.

// File: rtl/qm_pkg.sv
package qm_pkg;

    localparam int FLAG_W = 16;
    localparam int QID_W  = 10;
    localparam int VIF_W  = 5;
    localparam int PTR_W  = 20;
    localparam int LEN_W  = 11;
    localparam int QLEN_W = 24;

    // flag bit positions
    localparam int FLG_DROP   = 0;
    localparam int FLG_PLUGIN = 1;
    localparam int FLG_DGRAM  = 2;
    localparam int FLG_FINAL  = 3;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [QID_W-1:0]  qid;
        logic [VIF_W-1:0]  vif;
        logic [PTR_W-1:0]  ptr;
        logic [LEN_W-1:0]  len;
    } qm_desc_t;

endpackage

// File: rtl/qm_classify.sv
module qm_classify
    import qm_pkg::*;
#(
    parameter int LINKS = 8,
    parameter int NQ    = 256,
    parameter int DGQ   = 64,
    localparam int SETS  = LINKS + 1,
    localparam int SET_W = $clog2(SETS),
    localparam int QIX_W = $clog2(NQ),
    localparam int DG_W  = $clog2(DGQ)
)(
    input  logic [FLAG_W-1:0] flags,
    input  logic [QID_W-1:0]  qid,
    input  logic [VIF_W-1:0]  vif,
    output logic              route_ok,
    output logic [SET_W-1:0]  set_idx,
    output logic [QIX_W-1:0]  q_idx
);

    logic set_ok;
    logic q_ok;

    // R4: plugin flag overrides the interface
    always_comb begin
        if (flags[FLG_PLUGIN]) begin
            set_idx = SET_W'(LINKS);
            set_ok  = 1'b1;
        end else begin
            set_idx = SET_W'(vif);
            set_ok  = (int'(vif) < LINKS);
        end
    end

    // R5: datagram region folding, reserved range check
    always_comb begin
        if (flags[FLG_DGRAM]) begin
            q_idx = QIX_W'(qid[DG_W-1:0]);
            q_ok  = 1'b1;
        end else begin
            q_idx = QIX_W'(qid);
            q_ok  = (int'(qid) >= DGQ) && (int'(qid) < NQ);
        end
    end

    assign route_ok = set_ok && q_ok;

endmodule

// File: rtl/qm_rr_pick.sv
module qm_rr_pick #(
    parameter int W = 9,
    localparam int IW = (W > 1) ? $clog2(W) : 1
)(
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] pick
);

    function automatic logic [IW-1:0] wrap_add(logic [IW-1:0] base, int step);
        int s;
        s = int'(base) + step;
        if (s >= W) s = s - W;
        return IW'(s);
    endfunction

    // scan from the farthest candidate inwards; the nearest hit wins
    always_comb begin
        any  = |req;
        pick = last;
        for (int i = W; i >= 1; i--) begin
            if (req[wrap_add(last, i)]) pick = wrap_add(last, i);
        end
    end

endmodule

// File: rtl/qm_free_list.sv
module qm_free_list #(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    output logic [IW-1:0] top_idx,
    output logic [IW:0]   level
);

    logic [IW-1:0] slot_q [DEPTH];
    logic [IW-1:0] rd_q;
    logic [IW-1:0] wr_q;

    assign top_idx = slot_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= IW'(i);
            rd_q  <= '0;
            wr_q  <= '0;
            level <= (IW+1)'(DEPTH);
        end else begin
            if (pop) rd_q <= (rd_q == IW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            if (push) begin
                slot_q[wr_q] <= push_idx;
                wr_q <= (wr_q == IW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
            end
            level <= level + (IW+1)'(push) - (IW+1)'(pop);
        end
    end

endmodule

// File: rtl/qm_vlink_queue_mgr.sv
module qm_vlink_queue_mgr
    import qm_pkg::*;
#(
    parameter int LINKS = 8,
    parameter int NQ    = 256,
    parameter int DGQ   = 64,
    parameter int POOL  = 64,
    parameter int CNT_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FLAG_W-1:0] in_flags,
    input  logic [QID_W-1:0]  in_qid,
    input  logic [VIF_W-1:0]  in_vif,
    input  logic [PTR_W-1:0]  in_ptr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              deq_req,
    output logic              out_valid,
    output logic [FLAG_W-1:0] out_flags,
    output logic [QID_W-1:0]  out_qid,
    output logic [VIF_W-1:0]  out_vif,
    output logic [PTR_W-1:0]  out_ptr,
    output logic [LEN_W-1:0]  out_len,
    output logic [QLEN_W-1:0] out_qlen,
    output logic              out_release,
    output logic [CNT_W-1:0]  refuse_cnt
);

    localparam int SETS  = LINKS + 1;
    localparam int SET_W = $clog2(SETS);
    localparam int QIX_W = $clog2(NQ);
    localparam int TOTQ  = SETS * NQ;
    localparam int GQ_W  = $clog2(TOTQ);
    localparam int PW    = $clog2(POOL);

    function automatic logic [GQ_W-1:0] flat_q(logic [SET_W-1:0] s, logic [QIX_W-1:0] q);
        return GQ_W'(s) * GQ_W'(NQ) + GQ_W'(q);
    endfunction

    // queue table
    logic [TOTQ-1:0]   ne_q;
    logic [PW-1:0]     head_q [TOTQ];
    logic [PW-1:0]     tail_q [TOTQ];
    logic [QLEN_W-1:0] cnt_q  [TOTQ];

    // descriptor pool
    qm_desc_t      store_q [POOL];
    logic [PW-1:0] nxt_q   [POOL];

    // round-robin state
    logic [SET_W-1:0] last_set_q;
    logic [QIX_W-1:0] last_q_q [SETS];

    // ---------------- enqueue side ----------------
    logic             route_ok;
    logic [SET_W-1:0] e_set;
    logic [QIX_W-1:0] e_q;
    logic [GQ_W-1:0]  gq_e;
    logic             drop_in;
    logic             enq_go;
    logic             refuse;
    logic [PW-1:0]    fl_top;
    logic [PW:0]      fl_level;
    logic             pool_avail;
    qm_desc_t         in_desc;

    qm_classify #(.LINKS(LINKS), .NQ(NQ), .DGQ(DGQ)) u_cls (
        .flags    (in_flags),
        .qid      (in_qid),
        .vif      (in_vif),
        .route_ok (route_ok),
        .set_idx  (e_set),
        .q_idx    (e_q)
    );

    assign gq_e       = flat_q(e_set, e_q);
    assign drop_in    = in_flags[FLG_DROP];
    assign pool_avail = (fl_level != '0);
    // R3 drop is silent; R6 full pool refuses even with a pop this cycle
    assign enq_go     = in_valid && !drop_in && route_ok && pool_avail;
    assign refuse     = in_valid && !drop_in && !(route_ok && pool_avail);

    always_comb begin
        in_desc.flags = in_flags;
        in_desc.qid   = QID_W'(e_q);
        in_desc.vif   = in_vif;
        in_desc.ptr   = in_ptr;
        in_desc.len   = in_len;
    end

    // ---------------- dequeue selection ----------------
    logic [NQ-1:0]    set_vec [SETS];
    logic [SETS-1:0]  set_busy;
    logic             set_any;
    logic [SET_W-1:0] set_sel;
    logic             q_any;
    logic [QIX_W-1:0] q_sel;
    logic [GQ_W-1:0]  gq_d;
    logic             deq_go;

    for (genvar g = 0; g < SETS; g++) begin : g_set
        assign set_vec[g]  = ne_q[g*NQ +: NQ];
        assign set_busy[g] = |set_vec[g];
    end

    qm_rr_pick #(.W(SETS)) u_set_rr (
        .req  (set_busy),
        .last (last_set_q),
        .any  (set_any),
        .pick (set_sel)
    );

    qm_rr_pick #(.W(NQ)) u_q_rr (
        .req  (set_vec[set_sel]),
        .last (last_q_q[set_sel]),
        .any  (q_any),
        .pick (q_sel)
    );

    assign gq_d   = flat_q(set_sel, q_sel);
    assign deq_go = deq_req && set_any && q_any;

    // ---------------- free list ----------------
    qm_free_list #(.DEPTH(POOL)) u_free (
        .clk      (clk),
        .rst      (rst),
        .pop      (enq_go),
        .push     (deq_go),
        .push_idx (head_q[gq_d]),
        .top_idx  (fl_top),
        .level    (fl_level)
    );

    // ---------------- length bookkeeping ----------------
    logic              same_q;
    logic [QLEN_W-1:0] deq_cnt;
    logic [QLEN_W-1:0] enq_base;
    logic [QLEN_W-1:0] enq_cnt_new;
    logic              enq_relink;

    always_comb begin
        same_q      = deq_go && enq_go && (gq_d == gq_e);
        deq_cnt     = cnt_q[gq_d];
        enq_base    = ne_q[gq_e] ? cnt_q[gq_e] : '0;
        enq_cnt_new = enq_base + QLEN_W'(1) - QLEN_W'(same_q);
        // R12: a one-entry queue emptied this cycle restarts at the arrival
        enq_relink  = !ne_q[gq_e] || (same_q && deq_cnt == QLEN_W'(1));
    end

    // ---------------- state with reset ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ne_q       <= '0;
            last_set_q <= SET_W'(SETS-1);
            for (int s = 0; s < SETS; s++) last_q_q[s] <= QIX_W'(NQ-1);
            refuse_cnt <= '0;
        end else begin
            if (deq_go) begin
                if (deq_cnt == QLEN_W'(1)) ne_q[gq_d] <= 1'b0;
                last_set_q        <= set_sel;
                last_q_q[set_sel] <= q_sel;
            end
            if (enq_go) ne_q[gq_e] <= 1'b1;
            if (refuse) refuse_cnt <= refuse_cnt + 1'b1;
        end
    end

    // ---------------- link storage (no reset needed) ----------------
    always_ff @(posedge clk) begin
        if (deq_go) begin
            cnt_q[gq_d] <= deq_cnt - QLEN_W'(1);
            if (deq_cnt != QLEN_W'(1)) head_q[gq_d] <= nxt_q[head_q[gq_d]];
        end
        if (enq_go) begin
            store_q[fl_top] <= in_desc;
            cnt_q[gq_e]     <= enq_cnt_new;
            tail_q[gq_e]    <= fl_top;
            if (enq_relink) head_q[gq_e] <= fl_top;
            else            nxt_q[tail_q[gq_e]] <= fl_top;
        end
    end

    // ---------------- output register ----------------
    qm_desc_t head_desc;
    assign head_desc = store_q[head_q[gq_d]];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_release <= 1'b0;
        end else begin
            out_valid   <= deq_go;
            out_release <= deq_go && head_desc.flags[FLG_FINAL];
        end
    end

    always_ff @(posedge clk) begin
        if (deq_go) begin
            out_flags <= head_desc.flags;
            out_qid   <= head_desc.qid;
            out_vif   <= head_desc.vif;
            out_ptr   <= head_desc.ptr;
            out_len   <= head_desc.len;
            out_qlen  <= same_q ? enq_cnt_new : deq_cnt - QLEN_W'(1);
        end
    end

endmodule

// File: rtl/qm_vlq_checker.sv
module qm_vlq_checker #(
    parameter int POOL  = 64,
    parameter int CNT_W = 16,
    localparam int PW = $clog2(POOL)
)(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_drop,
    input logic             deq_req,
    input logic             out_valid,
    input logic             out_final,
    input logic             out_release,
    input logic [CNT_W-1:0] refuse_cnt,
    input logic [PW:0]      fl_level
);

    // R7: a returned descriptor always answers a request one cycle earlier
    a_r7_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(deq_req));

    // R7: no request, no output
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !deq_req |=> !out_valid);

    // R10: release strobe only with a valid final-copy descriptor
    a_r10_release_valid: assert property (@(posedge clk) disable iff (rst)
        out_release |-> (out_valid && out_final));

    a_r10_final_release: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_final) |-> out_release);

    // R3: dropped descriptors are not counted as refused
    a_r3_drop_uncounted: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_drop) |=> (refuse_cnt == $past(refuse_cnt)));

    // R6: refusals advance by at most one per cycle
    a_r6_refuse_step: assert property (@(posedge clk) disable iff (rst)
        (refuse_cnt == $past(refuse_cnt)) || (refuse_cnt == $past(refuse_cnt) + 1'b1));

    // R6: free slot count never exceeds the pool
    a_r6_pool_bound: assert property (@(posedge clk) disable iff (rst)
        int'(fl_level) <= POOL);

endmodule

bind qm_vlink_queue_mgr qm_vlq_checker #(.POOL(POOL), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_drop     (in_flags[qm_pkg::FLG_DROP]),
    .deq_req     (deq_req),
    .out_valid   (out_valid),
    .out_final   (out_flags[qm_pkg::FLG_FINAL]),
    .out_release (out_release),
    .refuse_cnt  (refuse_cnt),
    .fl_level    (fl_level)
);

// File: tb/qm_vlink_queue_mgr_tb.sv
module qm_vlink_queue_mgr_tb;

    localparam int LINKS = 8;
    localparam int NQ    = 256;
    localparam int DGQ   = 64;
    localparam int POOL  = 64;
    localparam int SETS  = LINKS + 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        in_valid;
    logic [15:0] in_flags;
    logic [9:0]  in_qid;
    logic [4:0]  in_vif;
    logic [19:0] in_ptr;
    logic [10:0] in_len;
    logic        deq_req;
    logic        out_valid;
    logic [15:0] out_flags;
    logic [9:0]  out_qid;
    logic [4:0]  out_vif;
    logic [19:0] out_ptr;
    logic [10:0] out_len;
    logic [23:0] out_qlen;
    logic        out_release;
    logic [15:0] refuse_cnt;

    qm_vlink_queue_mgr u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_flags(in_flags), .in_qid(in_qid), .in_vif(in_vif),
        .in_ptr(in_ptr), .in_len(in_len), .deq_req(deq_req),
        .out_valid(out_valid), .out_flags(out_flags), .out_qid(out_qid), .out_vif(out_vif),
        .out_ptr(out_ptr), .out_len(out_len), .out_qlen(out_qlen),
        .out_release(out_release), .refuse_cnt(refuse_cnt)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic [19:0] mq [SETS*NQ][$];
    logic [15:0] e_flags [4096];
    logic [4:0]  e_vif   [4096];
    logic [10:0] e_len   [4096];
    int          mlast_set;
    int          mlast_q [SETS];
    int          m_total;
    int          exp_refuse;
    logic [19:0] ptr_ctr;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit m_route(logic [15:0] f, logic [9:0] qid, logic [4:0] vif,
                                   output int s, output int q);
        s = f[1] ? LINKS : int'(vif);
        q = f[2] ? (int'(qid) % DGQ) : int'(qid);
        if (!f[1] && int'(vif) >= LINKS) return 0;
        if (f[2]) return 1;
        return (int'(qid) >= DGQ) && (int'(qid) < NQ);
    endfunction

    function automatic bit m_set_busy(int s);
        for (int k = 0; k < NQ; k++) if (mq[s*NQ+k].size() != 0) return 1;
        return 0;
    endfunction

    task automatic step(string tag, bit v, logic [15:0] f, logic [9:0] qid,
                        logic [4:0] vif, logic [10:0] len, bit dq);
        int s, q, ds, dqi, dg;
        bit ok, acc, xv;
        logic [19:0] xp;
        int xq, xlen;
        ds = 0; dqi = 0; dg = 0; xp = '0; xq = 0; xlen = 0;
        ok  = m_route(f, qid, vif, s, q);
        acc = v && !f[0] && ok && (m_total < POOL);
        if (v && !f[0] && !acc) exp_refuse++;
        xv = dq && (m_total > 0);
        if (xv) begin
            for (int i = SETS; i >= 1; i--) begin
                int c = (mlast_set + i) % SETS;
                if (m_set_busy(c)) ds = c;
            end
            for (int i = NQ; i >= 1; i--) begin
                int c = (mlast_q[ds] + i) % NQ;
                if (mq[ds*NQ+c].size() != 0) dqi = c;
            end
            dg = ds*NQ + dqi;
            xp = mq[dg].pop_front();
            xq = dqi;
            m_total--;
            mlast_set   = ds;
            mlast_q[ds] = dqi;
        end
        if (acc) begin
            e_flags[ptr_ctr[11:0]] = f;
            e_vif[ptr_ctr[11:0]]   = vif;
            e_len[ptr_ctr[11:0]]   = len;
            mq[s*NQ+q].push_back(ptr_ctr);
            m_total++;
        end
        if (xv) xlen = mq[dg].size();
        in_valid = v; in_flags = f; in_qid = qid; in_vif = vif;
        in_ptr = ptr_ctr; in_len = len; deq_req = dq;
        ptr_ctr = ptr_ctr + 20'd1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; deq_req = 1'b0;
        chk(tag, "out_valid", out_valid, xv);
        if (xv && out_valid) begin
            chk(tag, "out_ptr", out_ptr, xp);
            chk(tag, "out_qid", out_qid, xq);
            chk(tag, "out_flags", out_flags, e_flags[xp[11:0]]);
            chk(tag, "out_vif", out_vif, e_vif[xp[11:0]]);
            chk(tag, "out_len", out_len, e_len[xp[11:0]]);
            chk(tag, "out_qlen", out_qlen, xlen);
            chk(tag, "out_release", out_release, e_flags[xp[11:0]][3]);
        end else begin
            chk(tag, "out_release idle", out_release, 0);
        end
        chk(tag, "refuse_cnt", refuse_cnt, exp_refuse);
    endtask

    task automatic drain(string tag);
        while (m_total > 0) step(tag, 0, 16'h0, 10'd0, 5'd0, 11'd0, 1);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        mlast_set = SETS - 1;
        for (int s = 0; s < SETS; s++) mlast_q[s] = NQ - 1;
        m_total = 0; exp_refuse = 0; ptr_ctr = 20'd1;
        rst = 1'b1; in_valid = 1'b0; deq_req = 1'b0;
        in_flags = '0; in_qid = '0; in_vif = '0; in_ptr = '0; in_len = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", "out_valid after reset", out_valid, 0);
        chk("R1", "out_release after reset", out_release, 0);
        chk("R1", "refuse_cnt after reset", refuse_cnt, 0);
        step("R1 R7 empty request", 0, 16'h0, 10'd0, 5'd0, 11'd0, 1);

        // R2 / R11 order and length
        step("R2", 1, 16'h0004, 10'd5, 5'd0, 11'd100, 0);
        step("R2", 1, 16'h0004, 10'd5, 5'd0, 11'd200, 0);
        step("R2", 1, 16'h0004, 10'd5, 5'd0, 11'd300, 0);
        step("R2 R11", 0, 16'h0, 10'd0, 5'd0, 11'd0, 1);
        step("R11 same queue arrival", 1, 16'h0004, 10'd5, 5'd0, 11'd400, 1);
        drain("R2 R11");

        // R3 drop
        step("R3", 1, 16'h0005, 10'd6, 5'd1, 11'd10, 0);
        step("R3 nothing queued", 0, 16'h0, 10'd0, 5'd0, 11'd0, 1);

        // R4 plugin set and interface range
        step("R4 plugin", 1, 16'h0006, 10'd7, 5'd20, 11'd11, 0);
        step("R4 bad vif", 1, 16'h0004, 10'd7, 5'd9, 11'd12, 0);
        step("R4 bad vif 8", 1, 16'h0004, 10'd7, 5'd8, 11'd12, 0);
        drain("R4");

        // R5 datagram folding and reserved range
        step("R5 fold", 1, 16'h0004, 10'h3C5, 5'd3, 11'd13, 0);
        step("R5 low reserved", 1, 16'h0000, 10'd10, 5'd3, 11'd14, 0);
        step("R5 above N", 1, 16'h0000, 10'd300, 5'd3, 11'd15, 0);
        step("R5 reserved ok", 1, 16'h0000, 10'd100, 5'd3, 11'd16, 0);
        step("R5 edge", 1, 16'h0000, 10'd255, 5'd3, 11'd17, 0);
        drain("R5");

        // R10 final copy
        step("R10", 1, 16'h000C, 10'd1, 5'd4, 11'd18, 0);
        step("R10", 1, 16'h0004, 10'd1, 5'd4, 11'd19, 0);
        drain("R10");

        // R8 set rotation
        step("R8", 1, 16'h0004, 10'd1, 5'd2, 11'd20, 0);
        step("R8", 1, 16'h0004, 10'd2, 5'd5, 11'd21, 0);
        step("R8", 1, 16'h0006, 10'd3, 5'd0, 11'd22, 0);
        step("R8", 1, 16'h0004, 10'd4, 5'd2, 11'd23, 0);
        step("R8", 1, 16'h0004, 10'd0, 5'd0, 11'd24, 0);
        drain("R8");

        // R9 queue rotation inside one set
        step("R9", 1, 16'h0004, 10'd9, 5'd6, 11'd25, 0);
        step("R9", 1, 16'h0004, 10'd3, 5'd6, 11'd26, 0);
        step("R9", 1, 16'h0000, 10'd70, 5'd6, 11'd27, 0);
        step("R9", 1, 16'h0004, 10'd3, 5'd6, 11'd28, 0);
        step("R9", 1, 16'h0004, 10'd9, 5'd6, 11'd29, 0);
        drain("R9");

        // R12 single-entry queue with overlap
        step("R12", 1, 16'h0004, 10'd1, 5'd1, 11'd30, 0);
        step("R12 overlap", 1, 16'h0004, 10'd1, 5'd1, 11'd31, 1);
        step("R12 remaining", 0, 16'h0, 10'd0, 5'd0, 11'd0, 1);
        step("R12 empty", 0, 16'h0, 10'd0, 5'd0, 11'd0, 1);

        // R6 pool full
        for (int i = 0; i < POOL; i++)
            step("R6 fill", 1, 16'h0004, 10'(i % 7), 5'(i % 8), 11'(i), 0);
        step("R6 full refused", 1, 16'h0004, 10'd2, 5'd1, 11'd40, 0);
        step("R6 full with pop", 1, 16'h0004, 10'd2, 5'd1, 11'd41, 1);
        step("R6 room again", 1, 16'h0004, 10'd2, 5'd1, 11'd42, 0);
        drain("R6");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] f;
            logic [9:0]  qid;
            bit          dq;
            bit          fill_phase;
            fill_phase = ((n / 150) % 2) == 0;
            f    = 16'($urandom);
            f[0] = ($urandom % 8) == 0;
            f[1] = ($urandom % 4) == 0;
            if (f[2]) qid = 10'($urandom % 1024);
            else if (($urandom % 8) == 0) qid = 10'($urandom % 1024);
            else qid = 10'(64 + ($urandom % 6));
            dq = fill_phase ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
            step("R2 R8 R9 random", ($urandom % 4) != 0, f, qid,
                 5'($urandom % 10), 11'($urandom), dq);
        end
        drain("R2 random drain");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule